// File: doc/BRIEF.md
# NAND Volume Select Logic

This block lives inside a flash package controller that shares one chip enable line with up to fifteen other packages on an asynchronous NAND-style bus. It watches the write strobe on the system clock. On each rising edge of the write strobe while chip enable is low, it classifies the bus byte as a command or an address. With that, it decides whether this package is the volume the host is currently talking to.

A one-time set-identity command followed by an address byte programs a 4-bit volume identity. The identity then holds until the power-on reset input is asserted again. A select command followed by an address byte names a volume. The package becomes selected when the named volume matches its identity, and deselected otherwise. The selection is sticky: all other traffic leaves it unchanged.

While selected, the block passes ordinary command and address bytes downstream as single-cycle strobes. The internal die array is therefore seen behind one bus load. Before an identity exists, the package counts as selected, so the set-identity command can reach it.

Top module: `nand_vol_select`

## Requirements
- R1: A byte is captured only on a rising edge of `we_n` while `ce_n` is 0. It is a command when `cle`=1 and `ale`=0, and an address when `ale`=1 and `cle`=0. Any other combination of `cle`/`ale`, or `ce_n`=1, makes the write have no effect.
- R2: After `rst`, no identity is held, `selected` is 1 and `fwd_valid` is 0.
- R3: Command E2h followed by an address byte locks the identity to the low 4 bits of that byte. The upper 4 bits are ignored, and the package is selected after the lock.
- R4: Once an identity is locked, command E2h is ignored and the identity is unchanged. An address byte that follows it is treated as an ordinary address.
- R5: Command E1h followed by an address byte sets `selected` when the byte's low 4 bits equal the identity, and clears it otherwise. The upper 4 bits are ignored.
- R6: `selected` and the identity are unchanged by any command other than E1h/E2h, including the FFh reset command.
- R7: A command other than E1h/E2h, and an address not consumed by E1h/E2h, appear on `fwd_valid`/`fwd_data` only while `selected` is 1. `fwd_is_cmd` is 1 for commands. The strobe appears 2 clocks after the `we_n` rising edge is sampled. E1h, E2h and their address bytes are never forwarded.
- R8: `active` equals `selected` AND NOT `ce_n`.
- R9: While no identity is held, an E1h select sequence leaves the package selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the bus |
| rst | input | 1 | Synchronous active-high power-on reset; clears the identity |
| ce_n | input | 1 | Shared chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, bytes taken on its rising edge |
| dq | input | 8 | Bus data byte |
| selected | output | 1 | This package is the current volume |
| active | output | 1 | Selected and chip enable asserted |
| fwd_valid | output | 1 | One-cycle strobe of a forwarded byte |
| fwd_is_cmd | output | 1 | Forwarded byte is a command (else address) |
| fwd_data | output | 8 | Forwarded byte |

## Verification
A corrupted identity or pending-state register shows up at the next select sequence. `selected` takes the wrong value two clocks after the address strobe. From then on, every ordinary command is wrongly forwarded or wrongly dropped. A select opcode that leaks through, or a lost address classification, appears on `fwd_valid` within the same two-clock window. The bench therefore checks both `selected` and the forward strobe after every bus write, rather than only at the end of a sequence.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    localparam int DQ_W  = 8;
    localparam int VID_W = 4;

    localparam logic [DQ_W-1:0] OPC_SELECT = 8'hE1;
    localparam logic [DQ_W-1:0] OPC_SETID  = 8'hE2;

    typedef enum logic [1:0] {EV_NONE, EV_CMD, EV_ADDR} ev_kind_t;

    typedef struct packed {
        ev_kind_t        kind;
        logic [DQ_W-1:0] data;
    } bus_ev_t;

    typedef enum logic [1:0] {PD_IDLE, PD_SEL, PD_ID} pend_t;

    function automatic logic [VID_W-1:0] vid_of(input logic [DQ_W-1:0] b);
        return b[VID_W-1:0];
    endfunction
endpackage

// File: rtl/nvs_sampler.sv
module nvs_sampler
    import nvs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            cle,
    input  logic            ale,
    input  logic            we_n,
    input  logic [DQ_W-1:0] dq,
    output bus_ev_t         ev
);
    logic we_q;
    logic rise;

    assign rise = we_n & ~we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b1;
            ev.kind <= EV_NONE;
            ev.data <= '0;
        end else begin
            we_q    <= we_n;
            ev.kind <= EV_NONE;
            ev.data <= dq;
            if (rise && !ce_n) begin
                if (cle && !ale)      ev.kind <= EV_CMD;
                else if (ale && !cle) ev.kind <= EV_ADDR;
            end
        end
    end

    // R1: an event only follows a strobe edge taken under chip enable
    a_r1_ev_needs_ce: assert property (@(posedge clk) disable iff (rst)
        (ev.kind != EV_NONE) |-> ($past(!ce_n) && $past(we_n)));
endmodule

// File: rtl/nvs_tracker.sv
module nvs_tracker
    import nvs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_ev_t         ev,
    output logic            selected,
    output logic            fwd_valid,
    output logic            fwd_is_cmd,
    output logic [DQ_W-1:0] fwd_data
);
    pend_t             pend;
    logic              locked;
    logic              sel_q;
    logic [VID_W-1:0]  vid_q;

    assign selected = ~locked | sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= PD_IDLE;
            locked     <= 1'b0;
            sel_q      <= 1'b0;
            vid_q      <= '0;
            fwd_valid  <= 1'b0;
            fwd_is_cmd <= 1'b0;
            fwd_data   <= '0;
        end else begin
            fwd_valid <= 1'b0;
            unique case (ev.kind)
                EV_CMD: begin
                    pend <= PD_IDLE;
                    if (ev.data == OPC_SELECT) begin
                        pend <= PD_SEL;
                    end else if (ev.data == OPC_SETID) begin
                        if (!locked) pend <= PD_ID;
                    end else if (selected) begin
                        fwd_valid  <= 1'b1;
                        fwd_is_cmd <= 1'b1;
                        fwd_data   <= ev.data;
                    end
                end
                EV_ADDR: begin
                    pend <= PD_IDLE;
                    unique case (pend)
                        PD_SEL: if (locked) sel_q <= (vid_of(ev.data) == vid_q);
                        PD_ID: begin
                            vid_q  <= vid_of(ev.data);
                            locked <= 1'b1;
                            sel_q  <= 1'b1;
                        end
                        default: if (selected) begin
                            fwd_valid  <= 1'b1;
                            fwd_is_cmd <= 1'b0;
                            fwd_data   <= ev.data;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R4: a locked identity never changes and never unlocks
    a_r4_id_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(vid_q)));

    // R7: forwarding only follows a selected state
    a_r7_fwd_needs_sel: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> $past(selected));

    // R7: select opcode is never forwarded
    a_r7_no_fwd_select: assert property (@(posedge clk) disable iff (rst)
        (ev.kind == EV_CMD && ev.data == OPC_SELECT) |=> !fwd_valid);

    // R9: select before lock leaves the package selected
    a_r9_unlocked_stays: assert property (@(posedge clk) disable iff (rst)
        (!locked && ev.kind == EV_ADDR && pend == PD_SEL) |=> selected);
endmodule

// File: rtl/nand_vol_select.sv
module nand_vol_select
    import nvs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            cle,
    input  logic            ale,
    input  logic            we_n,
    input  logic [DQ_W-1:0] dq,
    output logic            selected,
    output logic            active,
    output logic            fwd_valid,
    output logic            fwd_is_cmd,
    output logic [DQ_W-1:0] fwd_data
);
    bus_ev_t ev;

    nvs_sampler u_sampler (
        .clk (clk), .rst (rst), .ce_n (ce_n), .cle (cle), .ale (ale),
        .we_n (we_n), .dq (dq), .ev (ev)
    );

    nvs_tracker u_tracker (
        .clk (clk), .rst (rst), .ev (ev), .selected (selected),
        .fwd_valid (fwd_valid), .fwd_is_cmd (fwd_is_cmd), .fwd_data (fwd_data)
    );

    assign active = selected & ~ce_n;

    // R2: no forward strobe in the cycle right after reset
    a_r2_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !fwd_valid);
endmodule

// File: tb/tb_nand_vol_select.sv
module tb_nand_vol_select;
    logic clk = 1'b0;
    logic rst, ce_n, cle, ale, we_n;
    logic [7:0] dq;
    logic selected, active, fwd_valid, fwd_is_cmd;
    logic [7:0] fwd_data;
    int n_chk = 0, n_bad = 0;
    logic fv, fc;
    logic [7:0] fd;

    always #4 clk = ~clk;

    nand_vol_select dut (
        .clk (clk), .rst (rst), .ce_n (ce_n), .cle (cle), .ale (ale),
        .we_n (we_n), .dq (dq), .selected (selected), .active (active),
        .fwd_valid (fwd_valid), .fwd_is_cmd (fwd_is_cmd), .fwd_data (fwd_data)
    );

    // {is_cmd, byte, expected selected, expected forward}
    localparam int NV = 21;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 8'h90, 1'b1, 1'b1},  // R7/R2 unlocked forwards
        {1'b1, 8'hE1, 1'b1, 1'b0},  // R9
        {1'b0, 8'h07, 1'b1, 1'b0},  // R9 stays selected
        {1'b1, 8'hE2, 1'b1, 1'b0},  // R3
        {1'b0, 8'hA5, 1'b1, 1'b0},  // R3 id=5
        {1'b1, 8'hE1, 1'b1, 1'b0},  // R5
        {1'b0, 8'h03, 1'b0, 1'b0},  // R5 mismatch
        {1'b1, 8'h00, 1'b0, 1'b0},  // R7 blocked
        {1'b0, 8'h12, 1'b0, 1'b0},  // R7 blocked addr
        {1'b1, 8'hE1, 1'b0, 1'b0},  // R5
        {1'b0, 8'hF5, 1'b1, 1'b0},  // R5 upper nibble ignored
        {1'b1, 8'h00, 1'b1, 1'b1},  // R7 cmd
        {1'b0, 8'h33, 1'b1, 1'b1},  // R7 addr
        {1'b1, 8'hFF, 1'b1, 1'b1},  // R6
        {1'b1, 8'hE2, 1'b1, 1'b0},  // R4 ignored
        {1'b0, 8'h09, 1'b1, 1'b1},  // R4 plain address
        {1'b1, 8'hE1, 1'b1, 1'b0},  // R4
        {1'b0, 8'h09, 1'b0, 1'b0},  // R4 id still 5
        {1'b1, 8'hFF, 1'b0, 1'b0},  // R6
        {1'b1, 8'hE1, 1'b0, 1'b0},  // R6
        {1'b0, 8'h05, 1'b1, 1'b0}   // R6 id survived
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives one write cycle, returns forward signals seen 2 clocks after the edge
    task automatic bus_wr(input logic c, input logic a, input logic ce, input logic [7:0] d);
        @(negedge clk);
        ce_n = ce; cle = c; ale = a; dq = d; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        fv = fwd_valid; fc = fwd_is_cmd; fd = fwd_data;
        cle = 1'b0; ale = 1'b0;
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; cle = 1'b0; ale = 1'b0; we_n = 1'b1; dq = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 selected", {8'h0, selected}, 9'h1);
        chk("R2 fwd_valid", {8'h0, fwd_valid}, 9'h0);
        chk("R8 active ce high", {8'h0, active}, 9'h0);

        for (int i = 0; i < NV; i++) begin
            bus_wr(VEC[i][10], ~VEC[i][10], 1'b0, VEC[i][9:2]);
            chk($sformatf("R5/R6 sel vec%0d", i), {8'h0, selected}, {8'h0, VEC[i][1]});
            chk($sformatf("R7 fwd vec%0d", i), {8'h0, fv}, {8'h0, VEC[i][0]});
            if (VEC[i][0])
                chk($sformatf("R7 data vec%0d", i), {fc, fd}, {VEC[i][10], VEC[i][9:2]});
        end
        chk("R8 active ce low", {8'h0, active}, 9'h1);

        // R1: writes with chip enable high are ignored
        bus_wr(1'b1, 1'b0, 1'b1, 8'hE1);
        bus_wr(1'b0, 1'b1, 1'b1, 8'h03);
        chk("R1 ce high no deselect", {8'h0, selected}, 9'h1);
        bus_wr(1'b1, 1'b0, 1'b1, 8'h30);
        chk("R1 ce high no fwd", {8'h0, fv}, 9'h0);
        chk("R8 ce high", {8'h0, active}, 9'h0);
        // R1: data cycle and both latches high are not captured
        bus_wr(1'b0, 1'b0, 1'b0, 8'h44);
        chk("R1 data cycle no fwd", {8'h0, fv}, 9'h0);
        bus_wr(1'b1, 1'b1, 1'b0, 8'h55);
        chk("R1 cle+ale no fwd", {8'h0, fv}, 9'h0);
        bus_wr(1'b1, 1'b0, 1'b0, 8'h80);
        chk("R1 plain cmd fwd", {fv, fd}, {1'b1, 8'h80});

        // R2: power-on reset clears the identity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R2 reselected", {8'h0, selected}, 9'h1);
        bus_wr(1'b1, 1'b0, 1'b0, 8'hE2);
        bus_wr(1'b0, 1'b1, 1'b0, 8'h3A);
        bus_wr(1'b1, 1'b0, 1'b0, 8'hE1);
        bus_wr(1'b0, 1'b1, 1'b0, 8'h05);
        chk("R3 new id 0xA rejects 5", {8'h0, selected}, 9'h0);
        bus_wr(1'b1, 1'b0, 1'b0, 8'hE1);
        bus_wr(1'b0, 1'b1, 1'b0, 8'h0A);
        chk("R3 new id 0xA accepts", {8'h0, selected}, 9'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule